// File: doc/BRIEF.md
# Programmable Real-Time Interrupt Generator

This block produces a periodic timeout from the bus clock. A free-running binary counter advances on every clock. Each time a chosen low-order slice of it wraps, a tick occurs. The chosen slice is 2^BASE_LOG2 cycles wide, extended by 0 to 3 more bits through a 2-bit rate field, which gives a period of 2^13, 2^14, 2^15 or 2^16 cycles by default. Each tick latches a status flag. Software may poll that flag or let it raise an interrupt request through an enable mask. Software acknowledges the flag with a one-cycle clear strobe.

Only reset stops or restarts the counter. Because of this, ticks stay on a fixed grid however late software clears the flag, and the first flag after reset comes exactly one full period after reset is released. A change of rate does not disturb the counter. The new period takes effect at the next wrap of the newly selected slice.

Top module: `rti_gen`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, flag_o and irq_o are 0.
- R2: The tick period is 2^(BASE_LOG2 + rate_sel_i) clock cycles. Code 00 gives ×1, 01 gives ×2, 10 gives ×4 and 11 gives ×8 of the base period.
- R3: Counting clock edges from the first edge at which rst_n is sampled high as edge 1, the first flag appears after edge P (P being the selected period) and not before.
- R4: Every tick sets flag_o on the next edge. flag_o can be polled with irq_en_i at 0, and irq_o then stays 0.
- R5: irq_o is a combinational level equal to flag_o AND irq_en_i. It follows a change of the mask within the same cycle.
- R6: A flag_clr_i pulse sampled high clears flag_o at that edge. With no tick and no clear, flag_o holds its value. A clear while the flag is already 0 leaves it 0.
- R7: Ticks fall on a fixed grid of multiples of P after reset, whatever cycle the flag is cleared in.
- R8: If a tick and a clear arrive at the same edge, flag_o stays set.
- R9: Changing rate_sel_i does not reset the counter. The next tick comes when the newly selected slice wraps, which is at the next multiple of the new period counted from reset.
- R10: The counter advances by one on every clock while out of reset. A reset in mid-run restarts it, so that the next first flag again needs a full period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_sel_i | input | 2 | Rate field: extra division by 1, 2, 4 or 8 |
| irq_en_i | input | 1 | Interrupt enable mask |
| flag_clr_i | input | 1 | One-cycle strobe that clears the flag |
| flag_o | output | 1 | Timeout status flag |
| irq_o | output | 1 | Interrupt request level |

## Verification
The assertions check several properties on every cycle. The counter steps by exactly one and restarts from zero after reset. Any tick sets the flag on the next edge, and a clear with no tick empties it. The flag holds when neither a tick nor a clear is present. irq_o never rises without both the flag and the mask. Some behaviour depends on absolute cycle positions, and only the bench scenarios can show it. That covers the exact cycle of the first flag for each rate code, the fixed grid under late clears, the clear-versus-tick collision, the boundary at which a rate change takes effect, and the full-period restart after a mid-run reset. The bench shortens the base exponent so that all four rates fit in a short run.

// File: rtl/rti_pkg.sv
// Package: shared constants and the rate-field encoding for the tick generator.
// Assumes the rate field picks a power-of-two extension of the base divider.
package rti_pkg;
    localparam int unsigned RATE_W        = 2;
    localparam int unsigned N_RATES       = 1 << RATE_W;
    localparam int unsigned BASE_LOG2_DEF = 13;

    typedef enum logic [RATE_W-1:0] {
        RATE_X1 = 2'd0,
        RATE_X2 = 2'd1,
        RATE_X4 = 2'd2,
        RATE_X8 = 2'd3
    } rate_e;
endpackage

// File: rtl/rti_prescaler.sv
// Module: free-running binary counter shared by every rate tap.
// Assumes a synchronous active-low reset is its only stop/restart control.
module rti_prescaler #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_q;

    // Advance by one on every clock; reset is the only restart.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    // R10: single-step advance while running.
    p_cnt_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

    // R10: counter restarts from zero after reset.
    p_cnt_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (cnt_q == '0));
endmodule

// File: rtl/rti_tap_mux.sv
// Module: derives one wrap strobe per rate from the shared counter and picks
// the one named by the rate field. Assumes CNT_W = BASE_LOG2 + N_RATES - 1.
module rti_tap_mux
    import rti_pkg::*;
#(
    parameter int unsigned BASE_LOG2 = BASE_LOG2_DEF,
    parameter int unsigned CNT_W     = BASE_LOG2 + N_RATES - 1
) (
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [RATE_W-1:0] sel_i,
    output logic              tick_o
);
    logic [N_RATES-1:0] wrap;

    // One wrap detector per rate: the low slice is all ones just before it rolls over.
    for (genvar g = 0; g < N_RATES; g++) begin : g_tap
        localparam int unsigned SLICE = BASE_LOG2 + g;
        assign wrap[g] = &cnt_i[SLICE-1:0];
    end

    // Select the strobe for the current rate code.
    always_comb begin
        tick_o = wrap[sel_i];
    end
endmodule

// File: rtl/rti_flag_ctl.sv
// Module: timeout flag with clear-by-strobe and masked interrupt level.
// Assumes tick_i is a one-cycle strobe and a tick wins over a clear.
module rti_flag_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic clr_i,
    input  logic mask_i,
    output logic flag_o,
    output logic irq_o
);
    logic flag_q;

    // Set on tick (with priority), clear on strobe, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_q <= 1'b0;
        else if (tick_i) flag_q <= 1'b1;
        else if (clr_i)  flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    // Interrupt request is a level gated by the mask.
    always_comb begin
        irq_o = flag_q & mask_i;
    end

    // R4, R8: any tick leaves the flag set afterwards.
    p_tick_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> flag_q);

    // R6: clear without tick empties the flag.
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !tick_i) |=> !flag_q);

    // R6: no tick and no clear means the flag holds.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !tick_i) |=> $stable(flag_q));
endmodule

// File: rtl/rti_gen.sv
// Module: top of the periodic tick generator. Chains the free-running counter,
// the rate tap selector and the flag/interrupt logic.
// Assumes a single clock domain and synchronous active-low reset.
module rti_gen
    import rti_pkg::*;
#(
    parameter int unsigned BASE_LOG2 = BASE_LOG2_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_sel_i,
    input  logic              irq_en_i,
    input  logic              flag_clr_i,
    output logic              flag_o,
    output logic              irq_o
);
    localparam int unsigned CNT_W = BASE_LOG2 + N_RATES - 1;

    logic [CNT_W-1:0] cnt;
    logic             tick;

    rti_prescaler #(.CNT_W(CNT_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_o (cnt)
    );

    rti_tap_mux #(.BASE_LOG2(BASE_LOG2), .CNT_W(CNT_W)) u_tap (
        .cnt_i  (cnt),
        .sel_i  (rate_sel_i),
        .tick_o (tick)
    );

    rti_flag_ctl u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .clr_i  (flag_clr_i),
        .mask_i (irq_en_i),
        .flag_o (flag_o),
        .irq_o  (irq_o)
    );

    // R5: no request without a pending flag.
    p_irq_needs_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag_o);

    // R5: no request while masked.
    p_irq_needs_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> irq_en_i);
endmodule

// File: tb/sim_rti_gen.sv
module sim_rti_gen;
    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel = 2'd0;
    logic       mask = 1'b0;
    logic       clr = 1'b0;
    logic       flag;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    rti_gen #(.BASE_LOG2(BASE)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .rate_sel_i (sel),
        .irq_en_i   (mask),
        .flag_clr_i (clr),
        .flag_o     (flag),
        .irq_o      (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Edge counter: edge 1 is the first edge with reset released.
    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    task automatic check(input int act, input int exp, input string req);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at cyc=%0d: actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        while (cyc != n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        clr   = 1'b0;
        repeat (4) @(negedge clk);
        check(flag, 0, "R1 flag in reset");
        check(irq, 0, "R1 irq in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(flag, 0, "R1 flag after release");
        check(irq, 0, "R1 irq after release");
    endtask

    // Clear strobe driven at a negedge, sampled at the next edge.
    task automatic pulse_clr();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic t_reset();
        mask = 1'b1;
        sel  = 2'd0;
        do_reset();
        mask = 1'b0;
    endtask

    task automatic t_first_period(input logic [1:0] s);
        int p;
        p = 16 << s;
        sel = s;
        do_reset();
        wait_cyc(p - 1);
        check(flag, 0, "R3 no flag before one period");
        wait_cyc(p);
        check(flag, 1, "R2 R3 flag at one period");
        wait_cyc(2 * p - 1);
        check(flag, 1, "R6 flag holds uncleared");
    endtask

    task automatic t_poll_mask();
        sel  = 2'd0;
        mask = 1'b0;
        do_reset();
        wait_cyc(16);
        check(flag, 1, "R4 flag pollable");
        check(irq, 0, "R4 irq masked");
        mask = 1'b1;
        #1 check(irq, 1, "R5 irq follows mask on");
        mask = 1'b0;
        #1 check(irq, 0, "R5 irq follows mask off");
        mask = 1'b1;
        #1;
        wait_cyc(16);
        pulse_clr();
        check(flag, 0, "R6 clear empties flag");
        check(irq, 0, "R5 irq drops with flag");
        pulse_clr();
        check(flag, 0, "R6 clear on empty flag");
        mask = 1'b0;
    endtask

    task automatic t_spacing();
        sel = 2'd1;
        do_reset();
        wait_cyc(32);
        check(flag, 1, "R7 first tick");
        wait_cyc(50);
        pulse_clr();
        wait_cyc(63);
        check(flag, 0, "R7 late clear, no early tick");
        wait_cyc(64);
        check(flag, 1, "R7 tick on grid after late clear");
        pulse_clr();
        wait_cyc(95);
        check(flag, 0, "R7 cleared before next tick");
        wait_cyc(96);
        check(flag, 1, "R7 tick on grid after early clear");
    endtask

    task automatic t_collision();
        sel = 2'd0;
        do_reset();
        wait_cyc(16);
        check(flag, 1, "R8 first tick");
        wait_cyc(31);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check(cyc, 32, "R8 collision edge");
        check(flag, 1, "R8 tick wins over clear");
        @(negedge clk);
        check(flag, 1, "R8 flag still set");
    endtask

    task automatic t_rate_change();
        sel = 2'd0;
        do_reset();
        wait_cyc(16);
        check(flag, 1, "R9 tick at old rate");
        pulse_clr();
        wait_cyc(20);
        sel = 2'd2;
        wait_cyc(48);
        check(flag, 0, "R9 no tick at old grid");
        wait_cyc(63);
        check(flag, 0, "R9 before new boundary");
        wait_cyc(64);
        check(flag, 1, "R9 tick at new boundary");
        pulse_clr();
        wait_cyc(70);
        sel = 2'd0;
        wait_cyc(79);
        check(flag, 0, "R9 before faster boundary");
        wait_cyc(80);
        check(flag, 1, "R9 tick at faster boundary");
    endtask

    task automatic t_restart();
        sel = 2'd3;
        do_reset();
        wait_cyc(100);
        do_reset();
        wait_cyc(127);
        check(flag, 0, "R10 no flag before full period after mid-run reset");
        wait_cyc(128);
        check(flag, 1, "R10 flag after full period");
    endtask

    initial begin
        t_reset();
        for (int s = 0; s < 4; s++) t_first_period(2'(s));
        t_poll_mask();
        t_spacing();
        t_collision();
        t_rate_change();
        t_restart();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule